// File: doc/BRIEF.md
# Cache-Line Staging Buffer with Wrapped Sub-Block Delivery

This block stages whole cache lines between a cache controller and a system bus. Each line is four 128-bit sub-blocks. The store is split into two banks. The read bank holds lines returned for outstanding misses. The writeback bank holds evicted lines that wait to go out. Lines enter through a fill port one beat per handshake. Each beat names a bank, a buffer index and a starting sub-block, and the beats land at consecutive wrapped positions from that start.

Lines leave through a single output port. A drain request on a read buffer delivers the requested sub-block first, then the following sub-blocks in order, wrapping from the last back to zero. A drain request on a writeback buffer always delivers from sub-block zero. A drain frees its buffer once the fourth beat has been taken, and only then.

A snoop port compares a line address against every pending writeback buffer in the same cycle. On a hit it streams that line out starting at the snooped sub-block. The buffer stays pending, so it can still be drained or snooped again later.

Top module: `line_buf_top`

## Requirements
- R1: After reset every buffer is free, out_valid is low, and snoop_hit is low for any address.
- R2: The k-th beat of a fill (k = 0..3) is stored at sub-block (fill_sub + k) mod 4. fill_wb = 1 selects the writeback bank (indices 0..1); fill_wb = 0 selects the read bank (indices 0..2). fill_ready is low for an index outside its bank, for a buffer that is not free, and for any other buffer while a fill is still in progress.
- R3: A read-buffer drain delivers its first beat at sub-block drain_sub, and each later beat at the previous sub-block plus one, modulo 4.
- R4: A writeback-buffer drain always delivers its first beat at sub-block 0. drain_sub has no effect on it.
- R5: Every transfer is exactly four accepted beats, and out_last is high on the fourth beat only.
- R6: drain_ready is high only when the output is idle, snoop_valid is low, and the addressed buffer holds a complete line.
- R7: snoop_hit is high in the same cycle when snoop_addr equals the address of a writeback buffer that holds a complete line. snoop_idx gives the lowest such index.
- R8: An accepted snoop that hits delivers that line starting at snoop_sub, wrapping. The writeback buffer stays pending afterwards.
- R9: An accepted snoop that misses produces no output beat.
- R10: A drained buffer becomes free after its fourth beat and can then be filled again.
- R11: While out_valid is high and out_ready is low, out_data, out_sub and out_last hold their values.
- R12: Each output beat carries exactly the 128-bit word that was written for that sub-block, with its bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill beat offered |
| fill_ready | output | 1 | Fill beat accepted |
| fill_wb | input | 1 | 1 = writeback bank, 0 = read bank |
| fill_idx | input | 2 | Buffer index within the bank |
| fill_sub | input | 2 | Starting sub-block of the fill |
| fill_addr | input | 32 | Line address, recorded for writeback fills |
| fill_data | input | 128 | Fill beat data |
| drain_valid | input | 1 | Drain request offered |
| drain_ready | output | 1 | Drain request accepted |
| drain_wb | input | 1 | 1 = writeback bank, 0 = read bank |
| drain_idx | input | 2 | Buffer index to drain |
| drain_sub | input | 2 | Requested first sub-block (read bank only) |
| snoop_valid | input | 1 | Snoop lookup offered |
| snoop_ready | output | 1 | Output engine idle, snoop accepted |
| snoop_addr | input | 32 | Line address looked up |
| snoop_sub | input | 2 | Desired first sub-block on a hit |
| snoop_hit | output | 1 | Lookup matched a pending writeback |
| snoop_idx | output | 2 | Matching writeback buffer index |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 128 | Output beat data |
| out_sub | output | 2 | Sub-block position of the output beat |
| out_last | output | 1 | Fourth beat of the transfer |

## Verification
The assertions watch the output stream on every cycle. They check that the first sub-block is right after each kind of start (read drain, writeback drain, snoop hit), that each beat steps to the next sub-block with wraparound, that the stream holds still under back-pressure, that a transfer is exactly four beats with the last flag on the fourth, and that a snoop miss produces nothing. Only the bench can show which word comes out at each position, that buffers are freed and refused at the right moments, and that a snooped line stays pending. It does so by keeping its own copy of every buffer's contents and state across directed corner cases and a seeded random mix of fills, drains and snoops.

// File: rtl/line_buf_pkg.sv
package line_buf_pkg;

   // Life cycle of one line buffer.
   typedef enum logic [1:0] {
      BUF_FREE     = 2'd0,
      BUF_FILLING  = 2'd1,
      BUF_FULL     = 2'd2,
      BUF_DRAINING = 2'd3
   } buf_state_e;

endpackage

// File: rtl/lb_store.sv
// Line storage: one write port, one combinational read port, addressed by
// {buffer id, sub-block}.
module lb_store #(
   parameter int GID_W  = 3,
   parameter int SUB_W  = 2,
   parameter int DATA_W = 128
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [GID_W-1:0]  wr_gid,
   input  logic [SUB_W-1:0]  wr_sub,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [GID_W-1:0]  rd_gid,
   input  logic [SUB_W-1:0]  rd_sub,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << (GID_W + SUB_W);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[{wr_gid, wr_sub}] <= wr_data;
   end

   assign rd_data = mem[{rd_gid, rd_sub}];
endmodule

// File: rtl/lb_snoop.sv
// Parallel address match over the writeback bank; lowest index wins.
module lb_snoop #(
   parameter int N_WB   = 2,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic [N_WB-1:0]   live,
   input  logic [ADDR_W-1:0] entry_addr [N_WB],
   input  logic [ADDR_W-1:0] look_addr,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);
   logic [N_WB-1:0] match;

   for (genvar i = 0; i < N_WB; i++) begin : g_cmp
      assign match[i] = live[i] && (entry_addr[i] == look_addr);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = N_WB - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |match;
endmodule

// File: rtl/lb_drain.sv
// Output sequencer: one transfer of BEATS beats from a wrapped start.
module lb_drain #(
   parameter int BEATS = 4,
   parameter int GID_W = 3,
   parameter int SUB_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [GID_W-1:0] start_gid,
   input  logic [SUB_W-1:0] start_sub,
   input  logic             start_free,
   input  logic             take,
   output logic             busy,
   output logic [GID_W-1:0] cur_gid,
   output logic [SUB_W-1:0] cur_sub,
   output logic             last,
   output logic             done_free
);
   logic [SUB_W-1:0] base_q;
   logic [SUB_W-1:0] cnt_q;
   logic             free_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cur_gid <= '0;
         base_q  <= '0;
         cnt_q   <= '0;
         free_q  <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy    <= 1'b1;
            cur_gid <= start_gid;
            base_q  <= start_sub;
            cnt_q   <= '0;
            free_q  <= start_free;
         end
      end else if (take) begin
         cnt_q <= cnt_q + 1'b1;
         if (last) busy <= 1'b0;
      end
   end

   assign cur_sub   = base_q + cnt_q;
   assign last      = (cnt_q == SUB_W'(BEATS - 1));
   assign done_free = busy && take && last && free_q;
endmodule

// File: rtl/line_buf_top.sv
module line_buf_top
   import line_buf_pkg::*;
#(
   parameter int N_RD   = 3,
   parameter int N_WB   = 2,
   parameter int BEATS  = 4,
   parameter int DATA_W = 128,
   parameter int ADDR_W = 32,
   localparam int IDX_W = (N_RD > N_WB) ? $clog2(N_RD) : $clog2(N_WB),
   localparam int SUB_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   output logic              fill_ready,
   input  logic              fill_wb,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [SUB_W-1:0]  fill_sub,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              drain_valid,
   output logic              drain_ready,
   input  logic              drain_wb,
   input  logic [IDX_W-1:0]  drain_idx,
   input  logic [SUB_W-1:0]  drain_sub,
   input  logic              snoop_valid,
   output logic              snoop_ready,
   input  logic [ADDR_W-1:0] snoop_addr,
   input  logic [SUB_W-1:0]  snoop_sub,
   output logic              snoop_hit,
   output logic [IDX_W-1:0]  snoop_idx,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [SUB_W-1:0]  out_sub,
   output logic              out_last
);
   localparam int NBUF  = N_RD + N_WB;
   localparam int GID_W = $clog2(NBUF);
   localparam int NSLOT = 1 << GID_W;

   // Elaboration-time parameter checks
   if (N_RD < 1 || N_WB < 1) begin : g_bad_banks
      $error("line_buf_top: both banks need at least one buffer");
   end
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("line_buf_top: BEATS must be a power of two, at least 2");
   end
   if (DATA_W < 8 || ADDR_W < 1) begin : g_bad_widths
      $error("line_buf_top: data or address width too small");
   end

   function automatic logic idx_ok(input logic wb, input logic [IDX_W-1:0] i);
      return wb ? (int'(i) < N_WB) : (int'(i) < N_RD);
   endfunction

   function automatic logic [GID_W-1:0] gid_of(input logic wb, input logic [IDX_W-1:0] i);
      return wb ? (GID_W'(N_RD) + GID_W'(i)) : GID_W'(i);
   endfunction

   buf_state_e        st [NSLOT];
   logic [ADDR_W-1:0] wb_addr [N_WB];

   // ---------------- fill side ----------------
   logic             f_active;
   logic [GID_W-1:0] f_gid;
   logic [SUB_W-1:0] f_base, f_cnt;
   logic [GID_W-1:0] fill_gid;
   logic             fill_fire, fill_first, fill_done;
   logic [SUB_W-1:0] fill_pos;

   assign fill_gid   = gid_of(fill_wb, fill_idx);
   assign fill_ready = idx_ok(fill_wb, fill_idx) &&
                       (f_active ? (fill_gid == f_gid) : (st[fill_gid] == BUF_FREE));
   assign fill_fire  = fill_valid && fill_ready;
   assign fill_first = fill_fire && !f_active;
   assign fill_done  = fill_fire && f_active && (f_cnt == SUB_W'(BEATS - 1));
   assign fill_pos   = f_active ? (f_base + f_cnt) : fill_sub;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_active <= 1'b0;
         f_gid    <= '0;
         f_base   <= '0;
         f_cnt    <= '0;
      end else if (fill_first) begin
         f_active <= 1'b1;
         f_gid    <= fill_gid;
         f_base   <= fill_sub;
         f_cnt    <= SUB_W'(1);
      end else if (fill_fire) begin
         f_cnt <= f_cnt + 1'b1;
         if (fill_done) f_active <= 1'b0;
      end
   end

   for (genvar w = 0; w < N_WB; w++) begin : g_wb_addr
      always_ff @(posedge clk) begin
         if (!rst_n) wb_addr[w] <= '0;
         else if (fill_first && fill_wb && fill_idx == IDX_W'(w)) wb_addr[w] <= fill_addr;
      end
   end

   // ---------------- snoop lookup ----------------
   logic [N_WB-1:0] wb_live;
   for (genvar w = 0; w < N_WB; w++) begin : g_live
      assign wb_live[w] = (st[N_RD + w] == BUF_FULL) || (st[N_RD + w] == BUF_DRAINING);
   end

   lb_snoop #(.N_WB(N_WB), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
      .live       (wb_live),
      .entry_addr (wb_addr),
      .look_addr  (snoop_addr),
      .hit        (snoop_hit),
      .hit_idx    (snoop_idx)
   );

   // ---------------- drain side ----------------
   logic             busy, done_free, snoop_take, drain_fire, start;
   logic [GID_W-1:0] drain_gid, start_gid, cur_gid;
   logic [SUB_W-1:0] start_sub;

   assign drain_gid   = gid_of(drain_wb, drain_idx);
   assign drain_ready = !busy && !snoop_valid && idx_ok(drain_wb, drain_idx) &&
                        (st[drain_gid] == BUF_FULL);
   assign drain_fire  = drain_valid && drain_ready;
   assign snoop_ready = !busy;
   assign snoop_take  = snoop_valid && !busy && snoop_hit;
   assign start       = drain_fire || snoop_take;
   assign start_gid   = snoop_take ? (GID_W'(N_RD) + GID_W'(snoop_idx)) : drain_gid;
   assign start_sub   = snoop_take ? snoop_sub : (drain_wb ? '0 : drain_sub);

   lb_drain #(.BEATS(BEATS), .GID_W(GID_W), .SUB_W(SUB_W)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_gid  (start_gid),
      .start_sub  (start_sub),
      .start_free (!snoop_take),
      .take       (out_ready),
      .busy       (busy),
      .cur_gid    (cur_gid),
      .cur_sub    (out_sub),
      .last       (out_last),
      .done_free  (done_free)
   );

   assign out_valid = busy;

   lb_store #(.GID_W(GID_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .wr_en   (fill_fire),
      .wr_gid  (fill_active_gid()),
      .wr_sub  (fill_pos),
      .wr_data (fill_data),
      .rd_gid  (cur_gid),
      .rd_sub  (out_sub),
      .rd_data (out_data)
   );

   function automatic logic [GID_W-1:0] fill_active_gid();
      return f_active ? f_gid : fill_gid;
   endfunction

   // ---------------- buffer state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NSLOT; b++) st[b] <= BUF_FREE;
      end else begin
         if (fill_first) st[fill_gid] <= BUF_FILLING;
         if (fill_done)  st[f_gid]    <= BUF_FULL;
         if (drain_fire) st[drain_gid] <= BUF_DRAINING;
         if (done_free)  st[cur_gid]  <= BUF_FREE;
      end
   end
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
   parameter int N_RD   = 3,
   parameter int N_WB   = 2,
   parameter int BEATS  = 4,
   parameter int DATA_W = 128,
   parameter int ADDR_W = 32,
   localparam int IDX_W = (N_RD > N_WB) ? $clog2(N_RD) : $clog2(N_WB),
   localparam int SUB_W = $clog2(BEATS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              drain_valid,
   input logic              drain_ready,
   input logic              drain_wb,
   input logic [SUB_W-1:0]  drain_sub,
   input logic              snoop_valid,
   input logic              snoop_ready,
   input logic [SUB_W-1:0]  snoop_sub,
   input logic              snoop_hit,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic [SUB_W-1:0]  out_sub,
   input logic              out_last
);
   logic [SUB_W-1:0] beat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) beat_cnt <= '0;
      else if (out_valid && out_ready) beat_cnt <= out_last ? '0 : beat_cnt + 1'b1;
   end

   assert_last_on_fourth_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |-> beat_cnt == SUB_W'(BEATS - 1));

   assert_last_only_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && beat_cnt == SUB_W'(BEATS - 1)) |-> out_last);

   assert_wrap_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last |=> out_valid && out_sub == SUB_W'($past(out_sub) + 1'b1));

   assert_read_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drain_valid && drain_ready && !drain_wb |=> out_valid && out_sub == $past(drain_sub));

   assert_wb_start_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      drain_valid && drain_ready && drain_wb |=> out_valid && out_sub == '0);

   assert_idle_on_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drain_ready |-> !out_valid && !snoop_valid);

   assert_snoop_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid && snoop_ready && snoop_hit |=> out_valid && out_sub == $past(snoop_sub));

   assert_snoop_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid && snoop_ready && !snoop_hit && !(drain_valid && drain_ready) |=> !out_valid);

   assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sub) && $stable(out_last));
endmodule

bind line_buf_top lb_checker #(
   .N_RD(N_RD), .N_WB(N_WB), .BEATS(BEATS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_wb(drain_wb), .drain_sub(drain_sub),
   .snoop_valid(snoop_valid), .snoop_ready(snoop_ready), .snoop_sub(snoop_sub), .snoop_hit(snoop_hit),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sub(out_sub), .out_last(out_last)
);

// File: tb/line_buf_top_test.sv
module line_buf_top_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fill_valid = 0, fill_wb = 0;
   logic [1:0]   fill_idx = 0, fill_sub = 0;
   logic [31:0]  fill_addr = 0;
   logic [127:0] fill_data = 0;
   logic         drain_valid = 0, drain_wb = 0;
   logic [1:0]   drain_idx = 0, drain_sub = 0;
   logic         snoop_valid = 0;
   logic [31:0]  snoop_addr = 0;
   logic [1:0]   snoop_sub = 0;
   logic         out_ready = 0;
   logic         fill_ready, drain_ready, snoop_ready, snoop_hit, out_valid, out_last;
   logic [1:0]   snoop_idx, out_sub;
   logic [127:0] out_data;

   int checks = 0, errors = 0;
   bit finished = 0;

   // bench model: buffers 0..2 read bank, 3..4 writeback bank
   logic [127:0] m_data [5][4];
   bit           m_full [5];
   logic [31:0]  m_addr [2];

   always #10 clk = ~clk;   // 50 MHz

   line_buf_top uut (.*);

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic bit in_bank(input bit wb, input int idx);
      return wb ? (idx < 2) : (idx < 3);
   endfunction

   function automatic int gid(input bit wb, input int idx);
      return wb ? 3 + idx : idx;
   endfunction

   function automatic int snoop_lookup(input logic [31:0] a);
      for (int i = 0; i < 2; i++) if (m_full[3 + i] && m_addr[i] == a) return i;
      return -1;
   endfunction

   // receive one transfer of four beats with random back-pressure
   task automatic collect(input int start, input int g, input bit frees, input string req);
      int k = 0, guard = 0;
      bit ok = 1;
      logic [127:0] bad_act = 0, bad_exp = 0;
      while (k < 4 && guard < 200) begin
         @(negedge clk);
         out_ready = ($urandom % 4) != 0;
         #1;
         if (out_valid && out_ready) begin
            int s = (start + k) % 4;
            if (out_sub != 2'(s) || out_data !== m_data[g][s] || out_last != (k == 3)) begin
               ok = 0; bad_act = {out_last, out_sub, out_data[123:0]}; bad_exp = {k == 3, 2'(s), m_data[g][s][123:0]};
            end
            k++;
         end
         guard++;
      end
      check(ok && k == 4, req, bad_act, bad_exp);
      @(negedge clk);
      out_ready = 1'b0;
      #1;
      check(!out_valid, "R5 no fifth beat", 128'(out_valid), 128'(0));
      if (frees) m_full[g] = 0;
   endtask

   task automatic do_fill(input bit wb, input int idx, input int start, input logic [31:0] a, input string req);
      bit expect_ok = in_bank(wb, idx) && !m_full[gid(wb, idx)];
      @(negedge clk);
      fill_valid = 1; fill_wb = wb; fill_idx = 2'(idx); fill_sub = 2'(start); fill_addr = a;
      fill_data = rnd128();
      #1;
      check(fill_ready == expect_ok, req, 128'(fill_ready), 128'(expect_ok));
      if (!expect_ok) begin
         fill_valid = 0;
         return;
      end
      for (int b = 0; b < 4; b++) begin
         if (b > 0) begin
            @(negedge clk);
            fill_data = rnd128();
            fill_sub = 2'($urandom);  // ignored after the first beat
         end
         m_data[gid(wb, idx)][(start + b) % 4] = fill_data;
         @(posedge clk);
      end
      @(negedge clk);
      fill_valid = 0;
      m_full[gid(wb, idx)] = 1;
      if (wb) m_addr[idx] = a;
   endtask

   task automatic do_drain(input bit wb, input int idx, input int sub, input string req);
      bit expect_ok = in_bank(wb, idx) && m_full[gid(wb, idx)];
      @(negedge clk);
      drain_valid = 1; drain_wb = wb; drain_idx = 2'(idx); drain_sub = 2'(sub);
      #1;
      check(drain_ready == expect_ok, "R6 drain acceptance", 128'(drain_ready), 128'(expect_ok));
      if (!expect_ok) begin
         drain_valid = 0;
         return;
      end
      @(posedge clk);
      #1 drain_valid = 0;
      collect(wb ? 0 : sub, gid(wb, idx), 1, req);
   endtask

   task automatic do_snoop(input logic [31:0] a, input int sub);
      int hit = snoop_lookup(a);
      @(negedge clk);
      snoop_valid = 1; snoop_addr = a; snoop_sub = 2'(sub);
      #1;
      check(snoop_hit == (hit >= 0) && (hit < 0 || snoop_idx == 2'(hit)), "R7 snoop lookup",
            {snoop_hit, snoop_idx}, {hit >= 0, 2'(hit)});
      check(snoop_ready, "R8 snoop ready when idle", 128'(snoop_ready), 128'(1));
      @(posedge clk);
      #1 snoop_valid = 0;
      if (hit >= 0) collect(sub, 3 + hit, 0, "R8 snoop delivery");
      else begin
         @(negedge clk);
         #1;
         check(!out_valid, "R9 snoop miss silent", 128'(out_valid), 128'(0));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 5; i++) m_full[i] = 0;
      m_addr[0] = 0; m_addr[1] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: reset state
      @(negedge clk);
      snoop_addr = 32'h0; drain_valid = 1; drain_idx = 0;
      #1;
      check(!out_valid, "R1 out idle", 128'(out_valid), 0);
      check(!snoop_hit, "R1 no snoop hit", 128'(snoop_hit), 0);
      check(!drain_ready, "R1 R6 nothing to drain", 128'(drain_ready), 0);
      drain_valid = 0;

      // R2/R3/R12: read fill from sub 2, drain from sub 1
      do_fill(0, 0, 2, 0, "R2 fill accept");
      do_fill(0, 0, 0, 0, "R2 busy buffer refused");
      do_fill(0, 3, 0, 0, "R2 out-of-bank refused");
      do_drain(0, 0, 1, "R3 R12 read drain wrap");
      do_fill(0, 0, 3, 0, "R10 refill after drain");
      do_drain(0, 0, 3, "R3 read drain from last sub");

      // R4: writeback filled from sub 3, drain asks sub 2, must start at 0
      do_fill(1, 1, 3, 32'hA000_0040, "R2 wb fill");
      do_drain(1, 1, 2, "R4 wb drain from zero");

      // R7/R8/R9: snoop hit, miss, pending after snoop
      do_fill(1, 0, 1, 32'hB000_0080, "R2 wb fill");
      do_fill(1, 1, 0, 32'hB000_0080, "R2 wb fill same addr");
      do_snoop(32'hB000_0080, 3);
      do_snoop(32'hC000_00C0, 0);
      do_snoop(32'hB000_0080, 1);
      do_fill(1, 0, 0, 32'h0, "R8 snooped wb still pending");
      do_drain(1, 0, 3, "R4 R10 drain snooped wb");
      do_snoop(32'hB000_0080, 2);
      do_drain(1, 1, 1, "R4 drain second wb");

      // random mix
      for (int n = 0; n < 400; n++) begin
         int op = $urandom % 3;
         bit wb = $urandom % 2;
         int idx = $urandom % 4;
         if (op == 0) do_fill(wb, idx, $urandom % 4, $urandom, "R2 R10 random fill");
         else if (op == 1) do_drain(wb, idx, $urandom % 4, wb ? "R4 random drain" : "R3 random drain");
         else begin
            logic [31:0] a = ($urandom % 2) ? m_addr[$urandom % 2] : $urandom;
            do_snoop(a, $urandom % 4);
         end
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule